// File: doc/BRIEF.md
# Integer Execute Unit with Compare Status

This block is the integer execute stage of a 32-bit processor. A decoder upstream hands it an 8-bit operation code, two register operands and a 16-bit immediate field. The block computes the result and a destination write strobe, and both appear on registered outputs one clock after the operation is presented. It covers two-operand add and subtract, their forms with an immediate, in-place increment and decrement, logical left and right shifts, seven bitwise functions, and a plain or sign-extending register copy.

The compare operation writes no register. It loads three status bits, equal, signed-greater and signed-less, into a status register. These bits hold their value until the next compare, so a conditional branch several instructions later can still test them. The register file, the writeback path and branch resolution live outside this block.

Top module: `alu_core`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes 0, `wr_en` becomes 0 and all three flags become 0, even when a compare code is applied at that time.
- R2: Code 0x19 produces `src_a + src_b` and code 0x1A produces `src_a - src_b`, both modulo 2^DATA_W, with `wr_en` = 1 on the edge after the code is applied.
- R3: Code 0x25 adds and code 0x26 subtracts the `imm` field, sign-extended from IMM_W bits, to or from `src_a`.
- R4: Code 0x15 yields `src_a + 1` and code 0x16 yields `src_a - 1`, both wrapping at the word boundary.
- R5: Code 0x17 shifts `src_a` left and code 0x18 shifts it right. Both shifts are logical and fill with zeros. The shift amount is the low log2(DATA_W) bits of `imm` when `shamt_from_imm` = 1, and of `src_b` when it is 0.
- R6: The bitwise codes are 0x1B AND, 0x1C OR, 0x1D NOT (`~src_a`, `src_b` is ignored), 0x1E XOR, 0x1F NAND, 0x20 NOR and 0x21 XNOR.
- R7: Code 0x01 copies `src_a` unchanged. Code 0x02 copies the low DATA_W/2 bits of `src_a` and sign-extends them to the full word.
- R8: Code 0x14 compares `src_a` with `src_b` as signed two's-complement values. On the following edge exactly one of `flag_eq`, `flag_gt` (a > b) and `flag_lt` (a < b) is set, and `wr_en` = 0.
- R9: No code other than 0x14 changes the three flags.
- R10: Every code not listed in R2 to R7 (0x14 and 0x00 included) gives `result` = 0 and `wr_en` = 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Decoded operation code |
| src_a | input | DATA_W | First register operand |
| src_b | input | DATA_W | Second register operand or shift-amount register |
| imm | input | IMM_W | Immediate field or literal shift amount |
| shamt_from_imm | input | 1 | 1: shift amount taken from `imm`; 0: taken from `src_b` |
| result | output | DATA_W | Registered result |
| wr_en | output | 1 | Registered destination write strobe |
| flag_eq | output | 1 | Status: last compare found equal |
| flag_gt | output | 1 | Status: last compare found a greater than b (signed) |
| flag_lt | output | 1 | Status: last compare found a less than b (signed) |

## Verification
A fault in the datapath or the decode shows up in `result` or `wr_en` one edge after the faulty operation, and nothing carries it into later cycles. A fault in the status register does carry forward. The bad value stays on the flags for every cycle until the next compare, so the flags are checked on every vector, and long runs of non-compare codes are placed between compares to expose a flag that drifts. With an 8-bit word the compare and every operand pairing can be swept in full, and the shifts, immediates and half-word sign extension each reach their sign and width boundaries.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [7:0] {
    OPC_NOP   = 8'h00,
    OPC_COPY  = 8'h01,
    OPC_COPYX = 8'h02,
    OPC_CMP   = 8'h14,
    OPC_INC   = 8'h15,
    OPC_DEC   = 8'h16,
    OPC_SHL   = 8'h17,
    OPC_SHR   = 8'h18,
    OPC_ADD   = 8'h19,
    OPC_SUB   = 8'h1A,
    OPC_AND   = 8'h1B,
    OPC_OR    = 8'h1C,
    OPC_NOT   = 8'h1D,
    OPC_XOR   = 8'h1E,
    OPC_NAND  = 8'h1F,
    OPC_NOR   = 8'h20,
    OPC_XNOR  = 8'h21,
    OPC_ADDI  = 8'h25,
    OPC_SUBI  = 8'h26
  } opc_e;

  typedef enum logic [2:0] {
    UNIT_NONE,
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_SHIFT,
    UNIT_MOVE
  } unit_e;

  typedef struct packed {
    unit_e unit;
    logic  wr;
    logic  cmp;
  } dec_s;

  function automatic dec_s decode_op(input logic [7:0] opc);
    dec_s d;
    d.unit = UNIT_NONE;
    case (opc)
      OPC_COPY, OPC_COPYX:                         d.unit = UNIT_MOVE;
      OPC_INC, OPC_DEC, OPC_ADD, OPC_SUB,
      OPC_ADDI, OPC_SUBI:                          d.unit = UNIT_ARITH;
      OPC_SHL, OPC_SHR:                            d.unit = UNIT_SHIFT;
      OPC_AND, OPC_OR, OPC_NOT, OPC_XOR,
      OPC_NAND, OPC_NOR, OPC_XNOR:                 d.unit = UNIT_LOGIC;
      default:                                     d.unit = UNIT_NONE;
    endcase
    d.wr  = (d.unit != UNIT_NONE);
    d.cmp = (opc == OPC_CMP);
    return d;
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [7:0]        opc,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] rhs;
  logic              do_sub;

  assign imm_sx = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  // One shared adder; subtraction uses the inverted operand plus carry-in.
  always_comb begin
    rhs    = b;
    do_sub = 1'b0;
    case (opc)
      OPC_INC:  rhs = DATA_W'(1);
      OPC_DEC:  begin rhs = DATA_W'(1); do_sub = 1'b1; end
      OPC_SUB:  do_sub = 1'b1;
      OPC_ADDI: rhs = imm_sx;
      OPC_SUBI: begin rhs = imm_sx; do_sub = 1'b1; end
      default:  rhs = b;
    endcase
  end

  assign res = a + (do_sub ? ~rhs : rhs) + DATA_W'(do_sub);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        opc,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);

  logic [1:0]        fn;
  logic              inv;
  logic [DATA_W-1:0] b_m;
  logic [DATA_W-1:0] base;

  // Base function (AND / OR / XOR) plus an output inversion covers all seven.
  always_comb begin
    fn  = 2'd0;
    inv = 1'b0;
    case (opc)
      OPC_AND:  begin fn = 2'd0; inv = 1'b0; end
      OPC_OR:   begin fn = 2'd1; inv = 1'b0; end
      OPC_XOR:  begin fn = 2'd2; inv = 1'b0; end
      OPC_NAND: begin fn = 2'd0; inv = 1'b1; end
      OPC_NOR:  begin fn = 2'd1; inv = 1'b1; end
      OPC_XNOR: begin fn = 2'd2; inv = 1'b1; end
      OPC_NOT:  begin fn = 2'd1; inv = 1'b1; end
      default:  begin fn = 2'd0; inv = 1'b0; end
    endcase
  end

  assign b_m = (opc == OPC_NOT) ? '0 : b;

  always_comb begin
    case (fn)
      2'd0:    base = a & b_m;
      2'd1:    base = a | b_m;
      default: base = a ^ b_m;
    endcase
  end

  assign res = inv ? ~base : base;

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              dir_right,
  input  logic [DATA_W-1:0] val,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic [DATA_W-1:0] stage [SH_W+1];

  // Right shifts reuse the left-shift stages on a bit-reversed word.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i]  = val[DATA_W-1-i];
    assign rev_out[i] = stage[SH_W][DATA_W-1-i];
  end

  assign stage[0] = dir_right ? rev_in : val;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign res = dir_right ? rev_out : stage[SH_W];

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              flag_eq,
  output logic              flag_gt,
  output logic              flag_lt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_eq <= 1'b0;
      flag_gt <= 1'b0;
      flag_lt <= 1'b0;
    end else if (cmp_en) begin
      flag_eq <= (a == b);
      flag_gt <= ($signed(a) > $signed(b));
      flag_lt <= ($signed(a) < $signed(b));
    end
  end

  a_r8_exactly_one: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !rst) |=> ($countones({flag_eq, flag_gt, flag_lt}) == 1));

  a_r8_never_two: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_eq, flag_gt, flag_lt}));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!cmp_en && !rst) |=> $stable({flag_eq, flag_gt, flag_lt}));

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              shamt_from_imm,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              flag_eq,
  output logic              flag_gt,
  output logic              flag_lt
);

  localparam int SH_W   = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;

  dec_s              dec;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic [DATA_W-1:0] shift_res;
  logic [DATA_W-1:0] move_res;
  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] res_d;

  assign dec = decode_op(opcode);

  alu_arith #(.DATA_W(DATA_W), .IMM_W(IMM_W)) arith_i (
    .opc (opcode),
    .a   (src_a),
    .b   (src_b),
    .imm (imm),
    .res (arith_res)
  );

  alu_logic #(.DATA_W(DATA_W)) logic_i (
    .opc (opcode),
    .a   (src_a),
    .b   (src_b),
    .res (logic_res)
  );

  assign shamt = shamt_from_imm ? imm[SH_W-1:0] : src_b[SH_W-1:0];

  alu_shift #(.DATA_W(DATA_W), .SH_W(SH_W)) shift_i (
    .dir_right (opcode == OPC_SHR),
    .val       (src_a),
    .amt       (shamt),
    .res       (shift_res)
  );

  assign move_res = (opcode == OPC_COPYX)
                  ? {{(DATA_W-HALF_W){src_a[HALF_W-1]}}, src_a[HALF_W-1:0]}
                  : src_a;

  always_comb begin
    case (dec.unit)
      UNIT_ARITH: res_d = arith_res;
      UNIT_LOGIC: res_d = logic_res;
      UNIT_SHIFT: res_d = shift_res;
      UNIT_MOVE:  res_d = move_res;
      default:    res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      wr_en  <= 1'b0;
    end else begin
      result <= res_d;
      wr_en  <= dec.wr;
    end
  end

  alu_flags #(.DATA_W(DATA_W)) flags_i (
    .clk     (clk),
    .rst     (rst),
    .cmp_en  (dec.cmp),
    .a       (src_a),
    .b       (src_b),
    .flag_eq (flag_eq),
    .flag_gt (flag_gt),
    .flag_lt (flag_lt)
  );

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!rst && !dec.wr) |=> (result == '0 && !wr_en));

  a_r2_add: assert property (@(posedge clk) disable iff (rst)
    (!rst && opcode == OPC_ADD) |=> (result == $past(src_a + src_b) && wr_en));

  a_r4_inc: assert property (@(posedge clk) disable iff (rst)
    (!rst && opcode == OPC_INC) |=> (result == $past(src_a + DATA_W'(1))));

  a_r5_zero_shift: assert property (@(posedge clk) disable iff (rst)
    (!rst && opcode == OPC_SHL && shamt_from_imm && imm[SH_W-1:0] == '0)
      |=> (result == $past(src_a)));

endmodule

// File: tb/alu_core_tb_top.sv
`timescale 1ns/1ps
module alu_core_tb_top;

  localparam int W  = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [7:0]    opcode;
  logic [W-1:0]  src_a, src_b;
  logic [IW-1:0] imm;
  logic          shamt_from_imm;
  logic [W-1:0]  result;
  logic          wr_en, flag_eq, flag_gt, flag_lt;

  int vectors = 0;
  int miscompares = 0;
  logic [2:0] ef = 3'b000;
  bit in_reset = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_core #(.DATA_W(W), .IMM_W(IW)) dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .src_a(src_a), .src_b(src_b),
    .imm(imm), .shamt_from_imm(shamt_from_imm), .result(result),
    .wr_en(wr_en), .flag_eq(flag_eq), .flag_gt(flag_gt), .flag_lt(flag_lt)
  );

  localparam logic [7:0] OPS [18] = '{8'h01, 8'h02, 8'h15, 8'h16, 8'h17, 8'h18,
    8'h19, 8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'h1E, 8'h1F, 8'h20, 8'h21, 8'h25, 8'h26, 8'h14};

  function automatic logic exp_wr(input logic [7:0] op);
    case (op)
      8'h01, 8'h02, 8'h15, 8'h16, 8'h17, 8'h18, 8'h19, 8'h1A, 8'h1B, 8'h1C,
      8'h1D, 8'h1E, 8'h1F, 8'h20, 8'h21, 8'h25, 8'h26: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_res(input logic [7:0] op, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [IW-1:0] im, input logic sel);
    logic [2:0]   sh;
    logic [W-1:0] sx;
    sh = sel ? im[2:0] : b[2:0];
    sx = {{(W-IW){im[IW-1]}}, im};
    case (op)
      8'h01: return a;                              // R7
      8'h02: return {{4{a[3]}}, a[3:0]};            // R7
      8'h15: return a + 8'd1;                       // R4
      8'h16: return a - 8'd1;                       // R4
      8'h17: return a << sh;                        // R5
      8'h18: return a >> sh;                        // R5
      8'h19: return a + b;                          // R2
      8'h1A: return a - b;                          // R2
      8'h1B: return a & b;                          // R6
      8'h1C: return a | b;
      8'h1D: return ~a;
      8'h1E: return a ^ b;
      8'h1F: return ~(a & b);
      8'h20: return ~(a | b);
      8'h21: return ~(a ^ b);
      8'h25: return a + sx;                         // R3
      8'h26: return a - sx;                         // R3
      default: return '0;                           // R10
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] op);
    if (in_reset) return "R1";
    case (op)
      8'h19, 8'h1A: return "R2";
      8'h25, 8'h26: return "R3";
      8'h15, 8'h16: return "R4";
      8'h17, 8'h18: return "R5";
      8'h01, 8'h02: return "R7";
      8'h14:        return "R8";
      default:      return (op >= 8'h1B && op <= 8'h21) ? "R6" : "R10";
    endcase
  endfunction

  task automatic apply(input logic [7:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [IW-1:0] im, input logic sel);
    logic [W-1:0] er;
    logic         ew;
    opcode = op; src_a = a; src_b = b; imm = im; shamt_from_imm = sel;
    @(negedge clk);
    if (in_reset) begin
      er = '0; ew = 1'b0; ef = 3'b000;
    end else begin
      er = exp_res(op, a, b, im, sel);
      ew = exp_wr(op);
      if (op == 8'h14)
        ef = {a == b, $signed(a) > $signed(b), $signed(a) < $signed(b)};
    end
    vectors++;
    if (result !== er || wr_en !== ew || {flag_eq, flag_gt, flag_lt} !== ef) begin
      miscompares++;
      $display("FAIL %s flags:%s op=%02h a=%02h b=%02h imm=%h sel=%b: result=%02h wr=%b flags=%03b expected result=%02h wr=%b flags=%03b",
               req_of(op), (op == 8'h14 && !in_reset) ? "R8" : (in_reset ? "R1" : "R9"),
               op, a, b, im, sel, result, wr_en, {flag_eq, flag_gt, flag_lt}, er, ew, ef);
    end
  endtask

  initial begin
    #780_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    opcode = 8'h00; src_a = '0; src_b = '0; imm = '0; shamt_from_imm = 1'b0;
    @(negedge clk);
    // R1: reset wins over a compare and an add
    apply(8'h14, 8'h05, 8'h03, 4'h0, 1'b0);
    apply(8'h19, 8'h05, 8'h03, 4'h0, 1'b0);
    rst = 1'b0;
    in_reset = 1'b0;
    // R8: set an initial flag state
    apply(8'h14, 8'h80, 8'h7F, 4'h0, 1'b0);
    // R2..R7, R9: every writing op, every a, eight b patterns
    foreach (OPS[i]) begin
      for (int a = 0; a < 256; a++) begin
        for (int k = 0; k < 8; k++) begin
          logic [W-1:0] bv;
          case (k)
            0: bv = 8'h00; 1: bv = 8'h01; 2: bv = 8'h7F; 3: bv = 8'h80;
            4: bv = 8'hFF; 5: bv = 8'h55; 6: bv = W'(a);
            default: bv = W'(a * 37 + 11);
          endcase
          apply(OPS[i], W'(a), bv, IW'(a) ^ bv[7:4], k[0]);
        end
      end
    end
    // R8: exhaustive signed compare
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(8'h14, W'(a), W'(b), 4'h0, 1'b0);
    // R10, R9: every opcode value, including unassigned ones
    for (int op = 0; op < 256; op++)
      apply(8'(op), 8'h5A, 8'h3C, 4'h9, op[0]);
    apply(8'h14, 8'h3C, 8'h3C, 4'h0, 1'b0);
    for (int op = 0; op < 256; op++)
      if (op != 8'h14) apply(8'(op), 8'hC3, 8'h11, 4'h6, op[1]);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule